// File: doc/BRIEF.md
# UART Transmitter with LIN Break Generation

This block serialises bytes onto a single line that rests high. A one-entry holding buffer takes a byte from the host. On a baud tick the byte moves into a shift register, and the shift register then sends it as a standard asynchronous frame. The host can also raise a send-break flag. While that flag is up, the next transfer from the buffer to the shift register ignores the buffered byte and sends a long low pulse. A bus master uses this pulse to announce a frame header.

A typical header sequence runs as follows:

1. Enable the transmitter.
2. Raise the break flag.
3. Write a dummy byte, which starts the break.
4. Write the sync byte 0x55 as soon as the buffer reports empty. It waits in the buffer while the break is shifting.

The flag drops by itself at the end of the break's stop bit. The waiting byte is then sent as an ordinary frame with no gap. Bit timing comes from an external one-cycle `baudTick` pulse. The block has no rate generator of its own.

Top module: `lin_break_tx`

## Requirements
- R1: After reset, `txOut` is 1, `bufEmpty` is 1, `shiftEmpty` is 1 and `sendBreak` is 0.
- R2: A transfer from the buffer to the shift register happens only on a clock with `baudTick` high. A normal frame is one low start bit, then the 8 data bits LSB first, then one high stop bit. Each bit lasts from one baud tick to the next. The start bit appears the cycle after the transfer.
- R3: A break frame drives 13 consecutive low bit times (the start bit plus 12 zero bits), followed by one high stop bit. The buffered byte has no effect on the line.
- R4: A frame is a break only if `sendBreak` is 1 and `txEnable` is 1 on the transfer clock. The frame type is latched at the transfer. Raising `sendBreak` during a frame does not change that frame.
- R5: `sendBreak` returns to 0 on the clock after the baud tick that ends a break's stop bit. A byte transferred on that same tick goes out as a normal frame.
- R6: While a frame is shifting, the buffer accepts the next byte. `bufEmpty` becomes 1 on the cycle after a transfer. A byte waiting at the end of a frame is transferred on that frame's final tick, so frames run back to back.
- R7: A write (`wrStb` high) while `bufEmpty` is 0 is dropped. The buffered byte is unchanged.
- R8: `shiftEmpty` is 0 from the cycle after a transfer until the cycle after the tick that ends the frame.
- R9: While `txEnable` is 0, `txOut` is 1 and no transfer happens. A frame in progress when `txEnable` falls is abandoned, and `shiftEmpty` is 1 on the next cycle.
- R10: A `breakSet` pulse makes `sendBreak` 1 on the next cycle. The flag stays set until the clear of R5. When the clear and a set fall on the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter enable |
| baudTick | input | 1 | One-cycle pulse marking each bit boundary |
| breakSet | input | 1 | Pulse that raises the send-break flag |
| wrStb | input | 1 | Buffer write strobe |
| wrData | input | 8 | Byte to buffer |
| txOut | output | 1 | Serial line, idles high |
| bufEmpty | output | 1 | Holding buffer can take a byte |
| shiftEmpty | output | 1 | No frame is shifting |
| sendBreak | output | 1 | Send-break flag (self-clearing) |

## Verification
The hardest case to reach is the end of a break with the sync byte already waiting. On that one tick the flag must clear, and the same tick must load the waiting byte as a normal frame, not as a second break. The bench reaches it by writing 0x55 as soon as `bufEmpty` rises after the dummy write. This leaves the sync byte in the buffer when the break's final tick arrives. A behavioural model compares every output on every cycle. Further scenarios cover raising the flag mid-frame, dropping the enable mid-frame and writing to a full buffer.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic loadFrame;   // move buffer into shift register
    logic loadBreak;   // the frame being loaded is a break
    logic shiftBit;    // advance to next bit
  } txStb_t;
endpackage

// File: rtl/lin_tx_datapath.sv
module lin_tx_datapath
  import lin_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BREAK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  txStb_t            stb,
  output logic              bufFull,
  output logic              serialBit
);
  localparam int SHIFT_W = BREAK_ZEROS + 2;
  localparam int PAD_W   = SHIFT_W - DATA_W - 2;

  logic [DATA_W-1:0]  bufData;
  logic [SHIFT_W-1:0] shiftReg;
  logic [SHIFT_W-1:0] normalVec;
  logic [SHIFT_W-1:0] breakVec;

  // Frame vectors, LSB goes out first
  generate
    if (PAD_W > 0) begin : g_pad
      assign normalVec = {{PAD_W{1'b1}}, 1'b1, bufData, 1'b0};
    end else begin : g_nopad
      assign normalVec = {1'b1, bufData, 1'b0};
    end
  endgenerate
  assign breakVec = {1'b1, {(SHIFT_W-1){1'b0}}};

  // Holding buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufData <= '0;
    end else if (stb.loadFrame) begin
      bufFull <= 1'b0;
    end else if (wrStb && !bufFull) begin
      bufFull <= 1'b1;
      bufData <= wrData;
    end
  end

  // Shift register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (stb.loadFrame) begin
      shiftReg <= stb.loadBreak ? breakVec : normalVec;
    end else if (stb.shiftBit) begin
      shiftReg <= {1'b1, shiftReg[SHIFT_W-1:1]};
    end
  end

  assign serialBit = shiftReg[0];

  assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && bufFull) |=> $stable(bufData));
  assert_empty_after_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadFrame |=> !bufFull);
endmodule

// File: rtl/lin_tx_ctrl.sv
module lin_tx_ctrl
  import lin_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BREAK_ZEROS = 12
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   txEnable,
  input  logic   baudTick,
  input  logic   breakSet,
  input  logic   bufFull,
  output txStb_t stb,
  output logic   active,
  output logic   sendBreak
);
  localparam int SHIFT_W = BREAK_ZEROS + 2;
  localparam int CNT_W   = $clog2(SHIFT_W);
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] BRK_LAST  = CNT_W'(SHIFT_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             isBreak;
  logic             lastBit, frameEnd, breakDone, breakNow, load;

  assign lastBit   = active && (bitCnt == (isBreak ? BRK_LAST : NORM_LAST));
  assign frameEnd  = baudTick && lastBit;
  assign breakDone = frameEnd && isBreak;
  // the flag is clearing this very tick: a frame loaded now is normal
  assign breakNow  = sendBreak && !breakDone;
  assign load      = txEnable && baudTick && bufFull && (!active || lastBit);

  always_comb begin
    stb.loadFrame = load;
    stb.loadBreak = load && breakNow;
    stb.shiftBit  = baudTick && active && !lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      bitCnt  <= '0;
      isBreak <= 1'b0;
    end else if (!txEnable) begin
      active  <= 1'b0;
      bitCnt  <= '0;
    end else if (load) begin
      active  <= 1'b1;
      bitCnt  <= '0;
      isBreak <= breakNow;
    end else if (frameEnd) begin
      active  <= 1'b0;
    end else if (baudTick && active) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          sendBreak <= 1'b0;
    else if (breakSet)  sendBreak <= 1'b1;
    else if (breakDone) sendBreak <= 1'b0;
  end

  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> !active);
  assert_break_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sendBreak) |-> $past(isBreak && active && baudTick));
  assert_kind_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (active && !load) |=> $stable(isBreak));
  assert_set_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    breakSet |=> sendBreak);
endmodule

// File: rtl/lin_break_tx.sv
module lin_break_tx
  import lin_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BREAK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              baudTick,
  input  logic              breakSet,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic              txOut,
  output logic              bufEmpty,
  output logic              shiftEmpty,
  output logic              sendBreak
);
  txStb_t stb;
  logic   bufFull, serialBit, active;

  lin_tx_ctrl #(.DATA_W(DATA_W), .BREAK_ZEROS(BREAK_ZEROS)) uCtrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .breakSet(breakSet), .bufFull(bufFull), .stb(stb), .active(active),
    .sendBreak(sendBreak)
  );

  lin_tx_datapath #(.DATA_W(DATA_W), .BREAK_ZEROS(BREAK_ZEROS)) uData (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .stb(stb),
    .bufFull(bufFull), .serialBit(serialBit)
  );

  assign txOut      = txEnable ? (active ? serialBit : 1'b1) : 1'b1;
  assign bufEmpty   = !bufFull;
  assign shiftEmpty = !active;

  assert_line_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |-> txOut);
endmodule

// File: tb/lin_break_tx_test.sv
module lin_break_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 0, rstN = 0, txEnable = 0, baudTick = 0, breakSet = 0, wrStb = 0;
  logic [7:0] wrData = 0;
  logic txOut, bufEmpty, shiftEmpty, sendBreak;

  int tests = 0, fails = 0, cyc = 0, tickCnt = 0;

  lin_break_tx uut (.clk(clk), .rstN(rstN), .txEnable(txEnable), .baudTick(baudTick),
    .breakSet(breakSet), .wrStb(wrStb), .wrData(wrData), .txOut(txOut),
    .bufEmpty(bufEmpty), .shiftEmpty(shiftEmpty), .sendBreak(sendBreak));

  always #(CLK_PERIOD/2) clk = ~clk;

  // baud tick pulse, changed shortly after the edge
  always @(posedge clk) begin
    #2;
    tickCnt = (tickCnt + 1) % TICK_DIV;
    baudTick = (tickCnt == 0);
  end

  // reference model
  bit mq[$];
  bit mActive, mFull, mSend, mIsBrk;
  bit [7:0] mBuf;
  bit last, endF, brkDone, brk, ld;

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); mActive = 0; mFull = 0; mSend = 0; mIsBrk = 0; mBuf = 0;
    end else begin
      last    = mActive && (mq.size() == 1);
      endF    = baudTick && last;
      brkDone = endF && mIsBrk;
      brk     = mSend && !brkDone;
      ld      = txEnable && baudTick && mFull && (!mActive || last);
      if (!txEnable) begin
        mActive = 0; mq.delete();
      end else if (ld) begin
        mq.delete();
        if (brk) begin
          for (int i = 0; i < 13; i++) mq.push_back(1'b0);
          mq.push_back(1'b1);
        end else begin
          mq.push_back(1'b0);
          for (int i = 0; i < 8; i++) mq.push_back(mBuf[i]);
          mq.push_back(1'b1);
        end
        mActive = 1; mIsBrk = brk;
      end else if (baudTick && mActive) begin
        void'(mq.pop_front());
        if (endF) mActive = 0;
      end
      if (ld) mFull = 0;
      else if (wrStb && !mFull) begin mFull = 1; mBuf = wrData; end
      if (breakSet) mSend = 1;
      else if (brkDone) mSend = 0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, act, exp);
    end
  endtask

  // compare every cycle, away from the clock edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      check("R2/R3 txOut", txOut, (txEnable && mActive && mq.size() > 0) ? mq[0] : 1'b1);
      check("R6/R7 bufEmpty", bufEmpty, !mFull);
      check("R8 shiftEmpty", shiftEmpty, !mActive);
      check("R5/R10 sendBreak", sendBreak, mSend);
    end
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(posedge clk); #2; wrStb = 1; wrData = d;
    @(posedge clk); #2; wrStb = 0;
  endtask

  task automatic pulseBreak();
    @(posedge clk); #2; breakSet = 1;
    @(posedge clk); #2; breakSet = 0;
  endtask

  task automatic waitBufEmpty();
    int n = 0;
    while (!bufEmpty && n < 500) begin step(1); n++; end
  endtask

  task automatic waitIdle();
    int n = 0;
    while (!(bufEmpty && shiftEmpty) && n < 1000) begin step(1); n++; end
    step(1);
  endtask

  initial begin
    step(3);
    // R1 reset state
    check("R1 txOut", txOut, 1'b1);
    check("R1 bufEmpty", bufEmpty, 1'b1);
    check("R1 shiftEmpty", shiftEmpty, 1'b1);
    check("R1 sendBreak", sendBreak, 1'b0);
    rstN = 1;
    step(2);
    // R9: disabled, a write stays in the buffer and the line stays high
    writeByte(8'h5A);
    step(12);
    check("R9 no load while off", bufEmpty, 1'b0);
    check("R9 line high while off", txOut, 1'b1);
    txEnable = 1;
    waitBufEmpty();
    // R6 preload and R7 dropped write
    writeByte(8'hA5);
    writeByte(8'hFF);
    waitIdle();
    // R3/R5 break followed by preloaded sync byte
    pulseBreak();
    check("R10 flag set", sendBreak, 1'b1);
    writeByte(8'hFF);
    waitBufEmpty();
    writeByte(8'h55);
    waitIdle();
    check("R5 flag cleared", sendBreak, 1'b0);
    // R4: raise flag during a normal frame
    writeByte(8'h3C);
    step(10);
    pulseBreak();
    writeByte(8'h00);
    waitIdle();
    // R9: abandon a frame mid-way
    writeByte(8'hC3);
    step(14);
    txEnable = 0;
    step(2);
    check("R9 abandoned", shiftEmpty, 1'b1);
    txEnable = 1;
    writeByte(8'h81);
    waitIdle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule